// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps the time of day and the calendar date in seven packed BCD registers: seconds, minutes, hours, day of week, date, month (with a century flag), and a two-digit year. A sub-second divider counts a 32.768 kHz enable input. Each time the divider completes a second, a small stepping state machine advances the fields. It starts at seconds and ripples a carry upward one field per clock cycle, only as far as a wrap makes necessary.

The hours register runs in either 24-hour or 12-hour format, selected by bit 6 of the hours value. The date wraps at the true end of each month, and February gains a 29th day whenever the year is divisible by four. A host loads any field through a plain register port (address, data, write strobe) and reads any field back combinationally. A write to seconds restarts the divider, so the next second boundary falls a full second after the write. A 1 Hz phase output is high during the second half of every second.

The stepping machine has the states ST_IDLE, ST_SEC, ST_MIN, ST_HOUR, ST_DATE, ST_MONTH and ST_YEAR, with these transitions:
- ST_IDLE goes to ST_SEC on a completed second.
- ST_SEC goes to ST_MIN, ST_MIN goes to ST_HOUR, and ST_HOUR goes to ST_DATE, each when the field it has just stepped wraps. For hours, the wrap is midnight.
- ST_DATE goes to ST_MONTH on the month end, and ST_MONTH goes to ST_YEAR after December.
- ST_YEAR always returns to ST_IDLE, and every other state returns to ST_IDLE when no carry is left.
- A seconds write forces ST_IDLE from any state.

Top module: `bcd_clock_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00 in 24-hour format, day 01, date 01, month 01 with century bit 0, and year 00. The 1 Hz output is low.
- R2: Seconds and minutes count in BCD from 00 to 59. Stepping from 59 gives 00 and carries to the next field.
- R3: With hours bit 6 clear, bits 5:0 hold BCD 00 to 23. Stepping from 23 gives 00 and advances day and date.
- R4: With hours bit 6 set, bits 4:0 hold BCD 01 to 12 and bit 5 is 1 for PM. The order is 11, 12, 01. PM flips on 11 to 12, and only 11 PM to 12 AM advances day and date.
- R5: Day of week steps 1 to 7 on each date advance, then wraps from 7 to 1.
- R6: Date wraps to 01 after 30 in April, June, September and November, and after 31 in the other long months. In February it wraps after 29 when the year value is divisible by 4, and after 28 otherwise.
- R7: Month steps 01 to 12 and wraps to 01, advancing the year. When year 99 wraps to 00, month bit 7 (century) toggles.
- R8: Addresses 0 to 6 select seconds, minutes, hours, day, date, month and year. A write stores on the strobe edge, and address 7 reads 00.
- R9: Bits that are always zero read back 0 whatever was written. These are bit 7 of seconds, minutes and hours, bits 7:3 of day, bits 7:6 of date, and bits 6:5 of month.
- R10: A seconds write clears the divider. The 1 Hz output is low on the next cycle, and the next second advance comes after exactly DIV_COUNT enables.
- R11: The 1 Hz output is high exactly while the enables counted since the last second boundary number at least DIV_COUNT/2.
- R12: A host write to a field in the same cycle that the field is being stepped wins and drops that field's carry. Writes to fields other than seconds leave the divider undisturbed.
- R13: The minute step follows the seconds step by one cycle. All carries land within 6 clock cycles after the enable that completes a second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_en | input | 1 | One-cycle enable per 32.768 kHz period |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 3 | Field select for writes |
| wr_data | input | 8 | Write data (BCD) |
| rd_addr | input | 3 | Field select for reads |
| rd_data | output | 8 | Selected field, combinational |
| pps_out | output | 1 | 1 Hz phase reference, high in second half of each second |

## Verification
The bench runs with a short divider, and it loads start times chosen just before each kind of rollover:
- second and minute ends;
- 23:59 in 24-hour format, and 11:59 AM and PM in 12-hour format;
- month ends in long and short months, and February in leap and plain years;
- 31 December of year 99.

Each of these shows whether a carry stops at the right field. Seeded random start times, biased toward the last legal value of each field, mix both hour formats and all months. These catch wrong month lengths or a missed century toggle that the directed cases skip. Separate patterns stop the enable stream halfway through a second, so the 1 Hz phase can be read. They also place a host write in the exact cycle a carry lands, which tells apart a write that wins from one that is overwritten.

// File: rtl/bcc_pkg.sv
package bcc_pkg;

    localparam int NREG  = 7;
    localparam int AW    = 3;
    localparam int NSTEP = 6;

    // Field indices, also the host addresses
    localparam int F_SEC   = 0;
    localparam int F_MIN   = 1;
    localparam int F_HOUR  = 2;
    localparam int F_DAY   = 3;
    localparam int F_DATE  = 4;
    localparam int F_MONTH = 5;
    localparam int F_YEAR  = 6;

    // Step strobe indices
    localparam int ADV_SEC   = 0;
    localparam int ADV_MIN   = 1;
    localparam int ADV_HOUR  = 2;
    localparam int ADV_DATE  = 3;
    localparam int ADV_MONTH = 4;
    localparam int ADV_YEAR  = 5;

    localparam logic [NREG-1:0][7:0] FIELD_MASK =
        {8'hFF, 8'h9F, 8'h3F, 8'h07, 8'h7F, 8'h7F, 8'h7F};
    localparam logic [NREG-1:0][7:0] FIELD_RST =
        {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEC,
        ST_MIN,
        ST_HOUR,
        ST_DATE,
        ST_MONTH,
        ST_YEAR
    } step_e;

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        logic [7:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

endpackage

// File: rtl/bcc_divider.sv
module bcc_divider #(
    parameter int DIV_COUNT = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clear,
    output logic sec_pulse,
    output logic pps
);
    localparam int CW = $clog2(DIV_COUNT);
    localparam logic [CW-1:0] LAST   = CW'(DIV_COUNT - 1);
    localparam logic [CW-1:0] HALF_C = CW'(DIV_COUNT / 2);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    assign sec_pulse = tick && !clear && (cnt_q == LAST);
    assign pps       = (cnt_q >= HALF_C);

endmodule

// File: rtl/bcc_step_fsm.sv
module bcc_step_fsm
    import bcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_pulse,
    input  logic             abort,
    input  logic [NSTEP-1:0] carry,
    output logic [NSTEP-1:0] adv
);
    step_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (abort) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:  st_d = sec_pulse          ? ST_SEC   : ST_IDLE;
                ST_SEC:   st_d = carry[ADV_SEC]     ? ST_MIN   : ST_IDLE;
                ST_MIN:   st_d = carry[ADV_MIN]     ? ST_HOUR  : ST_IDLE;
                ST_HOUR:  st_d = carry[ADV_HOUR]    ? ST_DATE  : ST_IDLE;
                ST_DATE:  st_d = carry[ADV_DATE]    ? ST_MONTH : ST_IDLE;
                ST_MONTH: st_d = carry[ADV_MONTH]   ? ST_YEAR  : ST_IDLE;
                ST_YEAR:  st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        adv = '0;
        unique case (st_q)
            ST_IDLE:  adv = '0;
            ST_SEC:   adv[ADV_SEC]   = 1'b1;
            ST_MIN:   adv[ADV_MIN]   = 1'b1;
            ST_HOUR:  adv[ADV_HOUR]  = 1'b1;
            ST_DATE:  adv[ADV_DATE]  = 1'b1;
            ST_MONTH: adv[ADV_MONTH] = 1'b1;
            ST_YEAR:  adv[ADV_YEAR]  = 1'b1;
            default:  adv = '0;
        endcase
    end

endmodule

// File: rtl/bcc_hour_step.sv
module bcc_hour_step
    import bcc_pkg::*;
(
    input  logic [7:0] hour_q,
    output logic [7:0] hour_nx,
    output logic       day_roll
);
    logic [7:0] h12;
    logic [7:0] tmp;
    logic       pm;

    always_comb begin
        hour_nx  = hour_q;
        day_roll = 1'b0;
        h12      = {3'b000, hour_q[4:0]};
        pm       = hour_q[5];
        tmp      = '0;
        if (hour_q[6]) begin
            if (h12 == 8'h11) begin
                hour_nx  = {2'b01, ~pm, 5'h12};
                day_roll = pm;
            end else if (h12 >= 8'h12) begin
                hour_nx = {2'b01, pm, 5'h01};
            end else begin
                tmp     = bcd_inc(h12);
                hour_nx = {2'b01, pm, tmp[4:0]};
            end
        end else begin
            if (hour_q[5:0] >= 6'h23) begin
                hour_nx  = 8'h00;
                day_roll = 1'b1;
            end else begin
                tmp     = bcd_inc({2'b00, hour_q[5:0]});
                hour_nx = {2'b00, tmp[5:0]};
            end
        end
    end

endmodule

// File: rtl/bcc_month_limit.sv
module bcc_month_limit (
    input  logic [4:0] month,
    input  logic [7:0] year,
    output logic [7:0] last_date
);
    logic [6:0] year_bin;
    logic       leap;

    assign year_bin = 7'(year[7:4]) * 7'd10 + 7'(year[3:0]);
    assign leap     = (year_bin[1:0] == 2'b00);

    always_comb begin
        unique case (month)
            5'h02:                      last_date = leap ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_clock_calendar.sv
module bcd_clock_calendar
    import bcc_pkg::*;
#(
    parameter int DIV_COUNT = 32768
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       osc_en,
    input  logic       wr_en,
    input  logic [2:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [2:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       pps_out
);
    logic [NREG-1:0][7:0] regs_q;
    logic [NREG-1:0][7:0] upd_val;
    logic [NREG-1:0]      upd_en;
    logic [NREG-1:0]      wr_hit;
    logic [NSTEP-1:0]     adv;
    logic [NSTEP-1:0]     carry;
    logic                 sec_pulse;
    logic                 sec_wr;
    logic [7:0]           hour_nx;
    logic                 day_roll;
    logic [7:0]           last_date;
    logic [7:0]           mon_inc;

    logic [7:0] sec_q, min_q, hour_q, day_q, date_q, month_q, year_q;
    assign sec_q   = regs_q[F_SEC];
    assign min_q   = regs_q[F_MIN];
    assign hour_q  = regs_q[F_HOUR];
    assign day_q   = regs_q[F_DAY];
    assign date_q  = regs_q[F_DATE];
    assign month_q = regs_q[F_MONTH];
    assign year_q  = regs_q[F_YEAR];

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            wr_hit[i] = wr_en && (wr_addr == AW'(i));
        end
    end
    assign sec_wr = wr_hit[F_SEC];

    bcc_divider #(.DIV_COUNT(DIV_COUNT)) i_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (osc_en),
        .clear     (sec_wr),
        .sec_pulse (sec_pulse),
        .pps       (pps_out)
    );

    bcc_step_fsm i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .abort     (sec_wr),
        .carry     (carry),
        .adv       (adv)
    );

    bcc_hour_step i_hour (
        .hour_q   (hour_q),
        .hour_nx  (hour_nx),
        .day_roll (day_roll)
    );

    bcc_month_limit i_lim (
        .month     (month_q[4:0]),
        .year      (year_q),
        .last_date (last_date)
    );

    // Carry out of each field, dropped when the host overwrites that field
    always_comb begin
        carry[ADV_SEC]   = (sec_q  >= 8'h59)       && !wr_hit[F_SEC];
        carry[ADV_MIN]   = (min_q  >= 8'h59)       && !wr_hit[F_MIN];
        carry[ADV_HOUR]  = day_roll                && !wr_hit[F_HOUR];
        carry[ADV_DATE]  = (date_q >= last_date)   && !wr_hit[F_DATE];
        carry[ADV_MONTH] = (month_q[4:0] >= 5'h12) && !wr_hit[F_MONTH];
        carry[ADV_YEAR]  = 1'b0;
    end

    assign mon_inc = bcd_inc({3'b000, month_q[4:0]});

    always_comb begin
        upd_en  = '0;
        upd_val = '0;
        if (adv[ADV_SEC]) begin
            upd_en[F_SEC]  = 1'b1;
            upd_val[F_SEC] = (sec_q >= 8'h59) ? 8'h00 : bcd_inc(sec_q);
        end
        if (adv[ADV_MIN]) begin
            upd_en[F_MIN]  = 1'b1;
            upd_val[F_MIN] = (min_q >= 8'h59) ? 8'h00 : bcd_inc(min_q);
        end
        if (adv[ADV_HOUR]) begin
            upd_en[F_HOUR]  = 1'b1;
            upd_val[F_HOUR] = hour_nx;
        end
        if (adv[ADV_DATE]) begin
            upd_en[F_DAY]   = 1'b1;
            upd_val[F_DAY]  = (day_q >= 8'h07) ? 8'h01 : day_q + 8'h01;
            upd_en[F_DATE]  = 1'b1;
            upd_val[F_DATE] = (date_q >= last_date) ? 8'h01 : bcd_inc(date_q);
        end
        if (adv[ADV_MONTH]) begin
            upd_en[F_MONTH]  = 1'b1;
            upd_val[F_MONTH] = (month_q[4:0] >= 5'h12) ? {month_q[7], 7'h01}
                                                       : {month_q[7], 2'b00, mon_inc[4:0]};
        end
        if (adv[ADV_YEAR]) begin
            upd_en[F_YEAR] = 1'b1;
            if (year_q >= 8'h99) begin
                upd_val[F_YEAR]  = 8'h00;
                upd_en[F_MONTH]  = 1'b1;
                upd_val[F_MONTH] = month_q ^ 8'h80;
            end else begin
                upd_val[F_YEAR] = bcd_inc(year_q);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= FIELD_RST;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (wr_hit[i])      regs_q[i] <= wr_data & FIELD_MASK[i];
                else if (upd_en[i]) regs_q[i] <= upd_val[i];
            end
        end
    end

    assign rd_data = (rd_addr < AW'(NREG)) ? regs_q[rd_addr] : 8'h00;

endmodule

// File: rtl/bcc_checker.sv
module bcc_checker
    import bcc_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             osc_en,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [2:0]       rd_addr,
    input logic [7:0]       rd_data,
    input logic             pps_out,
    input logic [NSTEP-1:0] adv,
    input logic [7:0]       sec_q,
    input logic [7:0]       month_q,
    input logic [7:0]       year_q
);
    // R10
    sec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd0) |=> !pps_out);

    // R11
    pps_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!osc_en && !(wr_en && wr_addr == 3'd0)) |=> $stable(pps_out));

    // R13
    min_after_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv[ADV_MIN] |-> $past(adv[ADV_SEC]));

    // R2
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv[ADV_SEC] && sec_q == 8'h59 && !(wr_en && wr_addr == 3'd0)) |=> (sec_q == 8'h00));

    // R7
    century_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv[ADV_YEAR] && year_q == 8'h99 && !(wr_en && (wr_addr == 3'd5 || wr_addr == 3'd6)))
        |=> (month_q[7] != $past(month_q[7])));

    // R9
    month_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr == 3'd5) |-> (rd_data[6:5] == 2'b00));

endmodule

bind bcd_clock_calendar bcc_checker i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .osc_en  (osc_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .pps_out (pps_out),
    .adv     (adv),
    .sec_q   (sec_q),
    .month_q (month_q),
    .year_q  (year_q)
);

// File: tb/test_bcd_clock_calendar.sv
`timescale 1ns/1ps
module test_bcd_clock_calendar;
    localparam int DIV = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       osc_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       pps_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model state, binary
    int m_sec, m_min, m_hr, m_day, m_date, m_mon, m_yr, m_cent;
    bit m_12;

    always #2 clk = ~clk;

    bcd_clock_calendar #(.DIV_COUNT(DIV)) i_bcd_clock_calendar (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .pps_out(pps_out)
    );

    function automatic logic [7:0] to_bcd(int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int dim(int mon, int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] model_byte(int idx);
        int h;
        case (idx)
            0: return to_bcd(m_sec);
            1: return to_bcd(m_min);
            2: begin
                if (!m_12) return to_bcd(m_hr);
                h = (m_hr % 12 == 0) ? 12 : m_hr % 12;
                return 8'h40 | ((m_hr >= 12) ? 8'h20 : 8'h00) | to_bcd(h);
            end
            3: return 8'(m_day);
            4: return to_bcd(m_date);
            5: return ((m_cent != 0) ? 8'h80 : 8'h00) | to_bcd(m_mon);
            6: return to_bcd(m_yr);
            default: return 8'h00;
        endcase
    endfunction

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_day = (m_day == 7) ? 1 : m_day + 1;
                    m_date++;
                    if (m_date > dim(m_mon, m_yr)) begin
                        m_date = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr++;
                            if (m_yr == 100) begin
                                m_yr = 0; m_cent ^= 1;
                            end
                        end
                    end
                end
            end
        end
    endtask

    task automatic check(string tag, string what, logic [7:0] got, logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%02h expected=%02h", tag, what, got, exp);
        end
    endtask

    task automatic rd(int a, output logic [7:0] v);
        rd_addr = 3'(a);
        #0.2;
        v = rd_data;
    endtask

    task automatic compare_all();
        logic [7:0] v;
        string tag;
        for (int idx = 0; idx < 7; idx++) begin
            rd(idx, v);
            case (idx)
                0, 1: tag = "R2";
                2: tag = m_12 ? "R4" : "R3";
                3: tag = "R5";
                4: tag = "R6";
                default: tag = "R7";
            endcase
            check(tag, $sformatf("field %0d", idx), v, model_byte(idx));
        end
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_time();
        for (int idx = 1; idx < 7; idx++) wr(idx, model_byte(idx));
        wr(0, model_byte(0));
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            osc_en = 1'b1;
        end
        @(negedge clk);
        osc_en = 1'b0;
    endtask

    task automatic run_second();
        ticks(DIV);
        repeat (6) @(negedge clk);
        model_step();
        compare_all();
    endtask

    task automatic load(bit f12, int yr, int mon, int date, int day, int hr, int mi, int s, int cent);
        m_12 = f12; m_yr = yr; m_mon = mon; m_date = date; m_day = day;
        m_hr = hr; m_min = mi; m_sec = s; m_cent = cent;
        set_time();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R13 watchdog: actual=hung expected=complete");
            finish_run();
        end
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd5173));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        m_12 = 0; m_sec = 0; m_min = 0; m_hr = 0; m_day = 1; m_date = 1;
        m_mon = 1; m_yr = 0; m_cent = 0;
        for (int idx = 0; idx < 7; idx++) begin
            rd(idx, v);
            check("R1", $sformatf("reset field %0d", idx), v, model_byte(idx));
        end
        check("R1", "reset pps", {7'b0, pps_out}, 8'h00);

        // R8 / R9 map and masking
        wr(3, 8'hFF); rd(3, v); check("R9", "day mask", v, 8'h07);
        wr(4, 8'hFF); rd(4, v); check("R9", "date mask", v, 8'h3F);
        wr(5, 8'hFF); rd(5, v); check("R9", "month mask", v, 8'h9F);
        wr(1, 8'hD5); rd(1, v); check("R9", "minute mask", v, 8'h55);
        wr(6, 8'h42); rd(6, v); check("R8", "year addr 6", v, 8'h42);
        rd(7, v);               check("R8", "addr 7 reads zero", v, 8'h00);

        // R2 / R3 plain rollover in 24-hour format
        load(0, 23, 5, 17, 3, 23, 59, 58, 0);
        compare_all();
        run_second(); run_second(); run_second();

        // R5 day 7 wraps to 1
        load(0, 23, 6, 10, 7, 23, 59, 59, 0);
        run_second();
        rd(3, v); check("R5", "day 7 to 1", v, 8'h01);

        // R6 leap and plain February, short month
        load(0, 28, 2, 28, 1, 23, 59, 59, 0);
        run_second();
        rd(4, v); check("R6", "leap Feb 28 -> 29", v, 8'h29);
        load(0, 23, 2, 28, 1, 23, 59, 59, 0);
        run_second();
        rd(5, v); check("R6", "plain Feb -> Mar", v, 8'h03);
        load(0, 23, 4, 30, 1, 23, 59, 59, 0);
        run_second();
        rd(4, v); check("R6", "Apr 30 -> 01", v, 8'h01);

        // R4 12-hour: 11 AM -> 12 PM no date change, 11 PM -> 12 AM date change
        load(1, 23, 5, 9, 2, 11, 59, 59, 0);
        run_second();
        rd(2, v); check("R4", "11AM -> 12PM", v, 8'h72);
        rd(4, v); check("R4", "date kept at noon", v, 8'h09);
        run_second();
        load(1, 23, 5, 9, 2, 12, 59, 59, 0);
        run_second();
        rd(2, v); check("R4", "12PM -> 01PM", v, 8'h61);
        load(1, 23, 5, 9, 2, 23, 59, 59, 0);
        run_second();
        rd(2, v); check("R4", "11PM -> 12AM", v, 8'h52);
        rd(4, v); check("R4", "date advances at midnight", v, 8'h10);

        // R7 / R13 full ripple with century toggle, sampled 6 cycles after last enable
        load(0, 99, 12, 31, 4, 23, 59, 59, 0);
        run_second();
        rd(6, v); check("R13", "year landed within 6 cycles", v, 8'h00);
        rd(5, v); check("R7", "century toggled, month 01", v, 8'h81);

        // R10 / R11 phase of the 1 Hz output
        load(0, 23, 7, 4, 5, 8, 30, 10, 0);
        check("R10", "pps low after seconds write", {7'b0, pps_out}, 8'h00);
        ticks(DIV / 2 - 1);
        check("R11", "pps low before half", {7'b0, pps_out}, 8'h00);
        ticks(1);
        check("R11", "pps high at half", {7'b0, pps_out}, 8'h01);
        ticks(DIV / 2 - 1);
        check("R11", "pps high in second half", {7'b0, pps_out}, 8'h01);
        rd(0, v); check("R10", "no advance before DIV enables", v, 8'h10);
        ticks(1);
        repeat (6) @(negedge clk);
        model_step();
        check("R11", "pps low after boundary", {7'b0, pps_out}, 8'h00);
        rd(0, v); check("R10", "advance after DIV enables", v, 8'h11);

        // R12 minute write mid-second keeps divider phase
        load(0, 23, 7, 4, 5, 8, 30, 10, 0);
        ticks(3);
        m_min = 45;
        wr(1, 8'h45);
        ticks(DIV - 3);
        repeat (6) @(negedge clk);
        model_step();
        rd(0, v); check("R12", "minute write left divider", v, 8'h11);
        rd(1, v); check("R12", "minute write stored", v, 8'h45);

        // R12 write lands in the cycle the minute step happens
        load(0, 23, 7, 4, 5, 5, 59, 59, 0);
        ticks(DIV);
        wr(1, 8'h30);
        repeat (5) @(negedge clk);
        rd(0, v); check("R12", "seconds wrapped", v, 8'h00);
        rd(1, v); check("R12", "write beats step", v, 8'h30);
        rd(2, v); check("R12", "carry dropped", v, 8'h05);

        // random start points near rollovers
        for (int it = 0; it < 30; it++) begin
            int yr, mon, dt, hr, mi, s;
            yr  = int'($urandom % 100);
            mon = 1 + int'($urandom % 12);
            dt  = ($urandom % 3 != 0) ? dim(mon, yr) - int'($urandom % 2)
                                      : 1 + int'($urandom % dim(mon, yr));
            case ($urandom % 5)
                0: hr = 23; 1: hr = 11; 2: hr = 12; 3: hr = 0;
                default: hr = int'($urandom % 24);
            endcase
            mi = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
            s  = 57 + int'($urandom % 3);
            load(bit'($urandom % 2), yr, mon, dt, 1 + int'($urandom % 7), hr, mi, s,
                 int'($urandom % 2));
            compare_all();
            for (int k = 0; k < 3; k++) run_second();
        end

        finish_run();
    end

endmodule